// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the slave side of a two-wire serial memory. It works from the system clock and samples the bus clock and data lines through a synchronizer. It drives only an open-drain pull-down enable for the data line. It recognises start and stop conditions and decodes the control byte. It keeps an 11-bit address pointer. Each received data byte is offered on a write stream. Read bytes are fetched from a memory port and shifted out most significant bit first.

The control byte carries a fixed four-bit device code, three block bits and a direction bit. In a write, the block bits become the top three bits of the pointer and the byte that follows supplies the low eight. While the external write-cycle sequencer reports busy, the engine stays fully silent. A read continues from wherever the pointer was left.

Write stream rules: `wr_valid` stays high, with `wr_addr` and `wr_data` unchanged, until the sink accepts with `wr_ready`. The bus cannot be stalled. If a byte completes while the previous one is still unaccepted, that byte is refused with a NACK and dropped. Read port rules: `rd_valid` stays high with `rd_addr` unchanged until `rd_ready`, and `rd_data` is taken in the handshake cycle. The memory must answer within a few system clocks, well inside one half of a bus clock period.

Top module: `ee_i2c_slave`

## Requirements
- R1: A falling data line while the clock is high is a start condition, and a rising data line while the clock is high is a stop condition. Either one abandons a transfer in progress, and an unfinished data byte is never offered on the write stream.
- R2: A control byte whose bits 7:4 equal 4'b1010 is acknowledged. The data line is held low for the whole high phase of the ninth clock.
- R3: A control byte with any other code gets no acknowledge. The engine then stays silent on every following byte until the next start.
- R4: While `busy_i` is high, no acknowledge is driven, even for a matching control byte of either direction.
- R5: In a write (control bit 0 = 0), control bits 3:1 set pointer bits 10:8 and the next byte sets pointer bits 7:0. Both are acknowledged. Each following data byte is acknowledged and offered with the current pointer as its address.
- R6: After each accepted data byte, only pointer bits 3:0 count up, wrapping inside the 16-byte page. Bits 10:4 stay as they were.
- R7: The write stream holds valid, address and data until ready. A data byte that completes while the previous byte is still pending gets a NACK, is dropped, and leaves the pointer unchanged.
- R8: `wr_commit` pulses for one clock on a stop that ends a transfer in which at least one data byte was accepted, and at no other time.
- R9: In a read (control bit 0 = 1), bytes come from the pointer, most significant bit first. The pointer steps by one over the full 11 bits after each fetch, wrapping from 0x7FF to 0x000.
- R10: A read continues from the current pointer. The block bits of a read control byte are ignored.
- R11: When the master does not acknowledge a read byte, the engine releases the data line and stays silent until the next start or stop.
- R12: `sda_oe` changes only while the clock is low, and never in the same system clock in which the falling clock is first seen.
- R13: After reset the engine is idle, the data line is released, both streams are idle, and the pointer is 0x000.
- R14: The read port holds `rd_valid` and `rd_addr` stable until `rd_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low |
| busy_i | input | 1 | Write cycle in progress; suppresses every acknowledge |
| wr_valid | output | 1 | Write stream byte available |
| wr_ready | input | 1 | Write stream sink accepts |
| wr_addr | output | 11 | Address of the offered byte |
| wr_data | output | 8 | Offered byte |
| wr_commit | output | 1 | One-clock pulse on a stop that ends a write with data |
| rd_valid | output | 1 | Read fetch request |
| rd_ready | input | 1 | Memory accepts the fetch; data valid |
| rd_addr | output | 11 | Fetch address |
| rd_data | input | 8 | Fetched byte |

## Verification
The in-line assertions check, on every cycle, the timing of data-line changes against the clock, silence after a rejected control byte, the hold rules of both streams, page-bound pointer stepping, the full-pointer wrap, and that commit pulses only follow a stop. Only the bench's scenarios can show the values on the bus. These include held acknowledges, page rollover overwriting earlier bytes, the address sequence across 0x7FF, and current-address reads after writes. They also include the NACK when back-pressure drops a byte, and the loss of a byte abandoned by a repeated start.

// File: rtl/ee_pkg.sv
package ee_pkg;
  localparam int BLK_W  = 3;
  localparam int WORD_W = 8;
  localparam int ADDR_W = BLK_W + WORD_W;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDAT,
    ST_RDAT,
    ST_IGN
  } ee_state_e;
endpackage

// File: rtl/ee_bus_sync.sv
module ee_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall_d,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe   <= '1;
      sda_pipe   <= '1;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
      scl_fall_d <= 1'b0;
    end else begin
      scl_pipe   <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe   <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q      <= scl_s;
      sda_q      <= sda_s;
      // falling edge acted on one clock late, so no data change meets SCL high
      scl_fall_d <= scl_q & ~scl_s;
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/ee_addr_ptr.sv
module ee_addr_ptr #(
  parameter int AW        = 11,
  parameter int BLK_W     = 3,
  parameter int PAGE_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_blk,
  input  logic [BLK_W-1:0]  blk,
  input  logic              set_low,
  input  logic [AW-BLK_W-1:0] low,
  input  logic              step_page,
  input  logic              step_full,
  output logic [AW-1:0]     ptr
);
  localparam int LOW_W = AW - BLK_W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ptr <= '0;
    else if (set_blk)   ptr[AW-1:LOW_W] <= blk;
    else if (set_low)   ptr[LOW_W-1:0] <= low;
    else if (step_page) ptr[PAGE_BITS-1:0] <= ptr[PAGE_BITS-1:0] + 1'b1;
    else if (step_full) ptr <= ptr + 1'b1;
  end

  // R6
  page_upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_page && !set_blk && !set_low) |=> ptr[AW-1:PAGE_BITS] == $past(ptr[AW-1:PAGE_BITS]));

  // R9
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_full && !step_page && !set_blk && !set_low && ptr == {AW{1'b1}}) |=> ptr == '0);
endmodule

// File: rtl/ee_i2c_slave.sv
module ee_i2c_slave
  import ee_pkg::*;
#(
  parameter int PAGE_BITS   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              busy_i,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              wr_commit,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [WORD_W-1:0] rd_data
);
  localparam logic [3:0] LAST_BIT = 4'd7;
  localparam logic [3:0] ACK_BIT  = 4'd8;
  localparam logic [3:0] SLOT_END = 4'd9;

  logic scl_s, sda_s, scl_rise, scl_fall_d, start_ev, stop_ev;
  ee_state_e st, nxt_q;
  logic [3:0] bitcnt;
  logic [WORD_W-1:0] sr, txb, byte_in;
  logic [2:0] bit_ix;
  logic [ADDR_W-1:0] ptr;
  logic ack_q, wr_any;
  logic ctrl_ok, byte_end, set_blk, set_low, step_page, step_full, rd_fire;

  ee_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall_d(scl_fall_d),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  assign byte_in   = {sr[WORD_W-2:0], sda_s};
  assign bit_ix    = 3'(LAST_BIT - bitcnt);
  assign ctrl_ok   = (byte_in[7:4] == DEV_CODE) && !busy_i;
  assign byte_end  = scl_rise && (bitcnt == LAST_BIT);
  assign set_blk   = byte_end && st == ST_CTRL && ctrl_ok && !byte_in[0];
  assign set_low   = byte_end && st == ST_ADDR && !busy_i;
  assign step_page = byte_end && st == ST_WDAT && !busy_i && !wr_valid;
  assign step_full = rd_valid && rd_ready;
  assign rd_fire   = (byte_end && st == ST_CTRL && ctrl_ok && byte_in[0]) ||
                     (scl_rise && bitcnt == ACK_BIT && st == ST_RDAT && !sda_s);
  assign rd_addr   = ptr;

  ee_addr_ptr #(.AW(ADDR_W), .BLK_W(BLK_W), .PAGE_BITS(PAGE_BITS)) u_ptr (
    .clk(clk), .rst_n(rst_n),
    .set_blk(set_blk), .blk(byte_in[3:1]),
    .set_low(set_low), .low(byte_in),
    .step_page(step_page), .step_full(step_full),
    .ptr(ptr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;  nxt_q <= ST_IDLE;
      bitcnt <= '0;   sr <= '0;  txb <= '1;
      ack_q <= 1'b0;  wr_any <= 1'b0;  sda_oe <= 1'b0;
      wr_valid <= 1'b0;  wr_addr <= '0;  wr_data <= '0;  wr_commit <= 1'b0;
      rd_valid <= 1'b0;
    end else begin
      wr_commit <= 1'b0;
      if (wr_valid && wr_ready) wr_valid <= 1'b0;
      if (step_full) begin
        rd_valid <= 1'b0;
        txb      <= rd_data;
      end
      if (rd_fire) rd_valid <= 1'b1;
      if (step_page) begin
        wr_valid <= 1'b1;
        wr_addr  <= ptr;
        wr_data  <= byte_in;
        wr_any   <= 1'b1;
      end

      if (start_ev) begin
        st <= ST_CTRL;  bitcnt <= '0;  sda_oe <= 1'b0;  wr_any <= 1'b0;
      end else if (stop_ev) begin
        st <= ST_IDLE;  sda_oe <= 1'b0;  wr_commit <= wr_any;  wr_any <= 1'b0;
      end else if (scl_rise && st != ST_IDLE) begin
        if (bitcnt != SLOT_END) bitcnt <= bitcnt + 4'd1;
        if (bitcnt < ACK_BIT) sr <= byte_in;
        if (bitcnt == LAST_BIT) begin
          case (st)
            ST_CTRL: begin
              ack_q <= ctrl_ok;
              nxt_q <= !ctrl_ok ? ST_IGN : (byte_in[0] ? ST_RDAT : ST_ADDR);
            end
            ST_ADDR: begin
              ack_q <= !busy_i;
              nxt_q <= busy_i ? ST_IGN : ST_WDAT;
            end
            ST_WDAT: begin
              ack_q <= step_page;
              nxt_q <= ST_WDAT;
            end
            ST_RDAT: begin
              ack_q <= 1'b0;
              nxt_q <= ST_RDAT;
            end
            default: begin
              ack_q <= 1'b0;
              nxt_q <= ST_IGN;
            end
          endcase
        end
        if (bitcnt == ACK_BIT && st == ST_RDAT && sda_s) nxt_q <= ST_IGN;
      end else if (scl_fall_d && st != ST_IDLE) begin
        if (bitcnt == ACK_BIT) begin
          sda_oe <= (st != ST_RDAT) && ack_q;
        end else if (bitcnt == SLOT_END) begin
          bitcnt <= '0;
          st     <= nxt_q;
          sda_oe <= (nxt_q == ST_RDAT) && !txb[WORD_W-1];
        end else if (st == ST_RDAT && bitcnt != 4'd0) begin
          sda_oe <= !txb[bit_ix];
        end else begin
          sda_oe <= 1'b0;
        end
      end
    end
  end

  // R12
  sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe) && !$past(start_ev) && !$past(stop_ev)) |-> (!scl_s && !$past(scl_s)));

  // R3
  silent_when_ignoring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IGN) |-> !sda_oe);

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  // R14
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R8
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_ev));
endmodule

// File: tb/ee_i2c_slave_test.sv
module ee_i2c_slave_test;
  localparam int HP = 8;
  localparam int MEMN = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic sda_oe, sda_line;
  logic wr_valid, wr_ready = 1'b0, wr_commit;
  logic [10:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  logic rd_valid, rd_ready = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  ee_i2c_slave uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .busy_i(busy), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_commit(wr_commit), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  logic [7:0] mem  [MEMN];
  logic [7:0] expm [MEMN];
  logic [10:0] wlog_a [64];
  logic [7:0]  wlog_d [64];
  int wn = 0, ncommit = 0, nchk = 0, nfail = 0, viol = 0;
  int rcnt = 0, wcnt = 0;
  logic hold_wr = 1'b0, oe_prev = 1'b0, scl_prev = 1'b1;
  logic [10:0] exp_ptr = '0;

  function automatic logic [7:0] seed_val(input int a);
    return 8'((a * 37 + 11) ^ (a >> 3));
  endfunction

  function automatic logic [10:0] page_next(input logic [10:0] a, input int k);
    return {a[10:4], 4'(a[3:0] + k)};
  endfunction

  assign rd_data = mem[rd_addr];

  always @(posedge clk) begin
    if (wr_valid && wr_ready) begin
      mem[wr_addr] = wr_data;
      if (wn < 64) begin wlog_a[wn] = wr_addr; wlog_d[wn] = wr_data; end
      wn++;
    end
    if (wr_commit) ncommit++;
  end

  always @(negedge clk) begin
    if (rd_ready) begin rd_ready = 1'b0; rcnt = $urandom % 4; end
    else if (rd_valid) begin if (rcnt == 0) rd_ready = 1'b1; else rcnt--; end
    if (wr_ready) begin wr_ready = 1'b0; wcnt = $urandom % 4; end
    else if (wr_valid && !hold_wr) begin if (wcnt == 0) wr_ready = 1'b1; else wcnt--; end
    // R12: slave output must not move while the bus clock is high
    if (scl_m && scl_prev && sda_oe != oe_prev) viol++;
    oe_prev = sda_oe;
    scl_prev = scl_m;
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hp();
    repeat (HP) @(negedge clk);
  endtask

  task automatic do_start();
    repeat (3) @(negedge clk); sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
    sda_m = 1'b0; hp(); scl_m = 1'b0;
  endtask

  task automatic do_stop();
    repeat (3) @(negedge clk); sda_m = 1'b0; hp(); scl_m = 1'b1; hp();
    sda_m = 1'b1; hp();
  endtask

  task automatic send_bit(input logic b);
    repeat (3) @(negedge clk); sda_m = b; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
  endtask

  // returns the bus value in the ack slot (0 = acknowledged) and whether it held
  task automatic send_byte(input logic [7:0] b, output logic nack, output logic held);
    logic s1, s2;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    repeat (3) @(negedge clk); sda_m = 1'b1; hp(); scl_m = 1'b1;
    @(negedge clk); s1 = sda_line;
    repeat (HP - 2) @(negedge clk); s2 = sda_line;
    @(negedge clk); scl_m = 1'b0;
    nack = s1; held = (s1 == s2);
  endtask

  task automatic recv_byte(input logic mnack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      repeat (3) @(negedge clk); sda_m = 1'b1; hp(); scl_m = 1'b1;
      repeat (HP / 2) @(negedge clk); b[i] = sda_line;
      repeat (HP - HP / 2) @(negedge clk); scl_m = 1'b0;
    end
    send_bit(mnack);
  endtask

  task automatic expect_ack(input string tag, input logic [7:0] b);
    logic n, h;
    send_byte(b, n, h);
    chk(tag, n, 0);
    chk({tag, " held"}, h, 1);
  endtask

  task automatic set_addr(input logic [10:0] a);
    do_start();
    expect_ack("R2 R5 ctrl write", {4'b1010, a[10:8], 1'b0});
    expect_ack("R5 word addr", a[7:0]);
    exp_ptr = a;
  endtask

  task automatic write_seq(input logic [10:0] a, input int n);
    int w0;
    logic [7:0] d;
    w0 = wn;
    set_addr(a);
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      expect_ack("R5 data ack", d);
      expm[page_next(a, i)] = d;
      if (w0 + i < 64) begin
        chk("R6 write addr", int'(wlog_a_get(w0 + i)), int'(page_next(a, i)));
      end
    end
    do_stop();
    repeat (4) @(negedge clk);
    chk("R5 write count", wn - w0, n);
    exp_ptr = page_next(a, n);
  endtask

  function automatic logic [10:0] wlog_a_get(input int k);
    return (k < 64) ? wlog_a[k] : 11'h0;
  endfunction

  task automatic read_cur(input logic [2:0] blk, input int n, input bit extra);
    logic [7:0] b;
    logic nk, hd;
    do_start();
    send_byte({4'b1010, blk, 1'b1}, nk, hd);
    chk("R2 ctrl read ack", nk, 0);
    for (int i = 0; i < n; i++) begin
      recv_byte(i == n - 1, b);
      chk("R9 R10 R14 read data", b, expm[exp_ptr]);
      exp_ptr = exp_ptr + 11'd1;
    end
    if (extra) begin
      recv_byte(1'b1, b);
      chk("R11 released after master nack", b, 8'hFF);
    end
    do_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    logic n, h;
    int w0, c0;
    logic [10:0] a;
    logic [7:0] d0;
    process::self().srandom(32'd20241);
    for (int i = 0; i < MEMN; i++) begin mem[i] = seed_val(i); expm[i] = seed_val(i); end
    repeat (5) @(negedge clk);
    chk("R13 sda released", sda_oe, 0);
    chk("R13 write idle", wr_valid, 0);
    chk("R13 read idle", rd_valid, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R13 R10: pointer starts at zero
    read_cur(3'b110, 2, 0);

    // R5 R8: directed write then random read back
    c0 = ncommit;
    write_seq(11'h2F3, 3);
    chk("R8 commit pulse", ncommit - c0, 1);
    set_addr(11'h2F2);
    read_cur(3'b000, 5, 0);

    // R6: page rollover overwrites earlier bytes
    write_seq(11'h45C, 18);
    set_addr(11'h450);
    read_cur(3'b011, 16, 0);

    // R9: full pointer wrap
    set_addr(11'h7FE);
    read_cur(3'b111, 4, 0);

    // R10: current address read after a write, foreign block bits
    write_seq(11'h1A7, 2);
    read_cur(3'b101, 3, 0);

    // R11: master nack then extra clocks
    read_cur(3'b000, 2, 1);

    // R3: wrong device code, silence afterwards
    do_start();
    send_byte(8'hB0, n, h); chk("R3 mismatch nack", n, 1);
    send_byte(8'h12, n, h); chk("R3 silent after mismatch", n, 1);
    send_byte(8'h00, n, h); chk("R3 still silent", n, 1);
    do_stop();

    // R4: busy blocks every acknowledge
    busy = 1'b1;
    do_start();
    send_byte(8'hA4, n, h); chk("R4 busy write ctrl nack", n, 1);
    do_start();
    send_byte(8'hA1, n, h); chk("R4 busy read ctrl nack", n, 1);
    do_stop();
    busy = 1'b0;
    repeat (5) @(negedge clk);

    // R1: repeated start abandons a half data byte
    w0 = wn; c0 = ncommit;
    set_addr(11'h333);
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    do_start();
    do_stop();
    repeat (6) @(negedge clk);
    chk("R1 no partial write", wn - w0, 0);
    chk("R1 R8 no commit", ncommit - c0, 0);
    read_cur(3'b000, 1, 0);

    // R7: back-pressure drops the second byte
    hold_wr = 1'b1;
    w0 = wn;
    set_addr(11'h100);
    d0 = 8'h5A;
    expect_ack("R7 first byte ack", d0);
    send_byte(8'hC3, n, h); chk("R7 pending byte nack", n, 1);
    chk("R7 valid held", wr_valid, 1);
    chk("R7 data held", wr_data, 8'h5A);
    do_stop();
    hold_wr = 1'b0;
    repeat (10) @(negedge clk);
    chk("R7 single handshake", wn - w0, 1);
    expm[11'h100] = d0;
    exp_ptr = 11'h101;
    set_addr(11'h100);
    read_cur(3'b000, 2, 0);

    // random mix
    for (int it = 0; it < 5; it++) begin
      a = 11'($urandom);
      write_seq(a, 1 + int'($urandom % 10));
      set_addr(11'($urandom));
      read_cur(3'($urandom), 1 + int'($urandom % 8), 0);
    end

    chk("R12 no change with clock high", viol, 0);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule